// File: doc/BRIEF.md
# Vertical-Crosswise Unsigned Multiplier

This block multiplies two 8-bit unsigned operands and delivers the full 16-bit product. Every bit product is formed at once. No shift-and-add sequence steps through the multiplier bits. Instead, a two-bit crosswise cell produces a 4-bit result from its inputs in parallel. Four such cells, combined by ripple-carry addition of their shifted results, make a 4x4 multiplier. Four 4x4 multipliers, combined the same way, make the 8x8 product.

At each level, the product of the low halves sits at weight zero. The two cross products (low by high and high by low) sit at weight half the operand width. The product of the high halves sits at weight equal to the operand width. The product is therefore the column-wise sum of concurrently formed partial products, with the carries moving from the lower columns to the higher ones.

A parameter selects whether the product leaves the block through an output register or straight from the adder tree. The default is registered, with an active-low asynchronous reset.

Top module: `vc_mult8`

## Requirements
- R1: For every pair of 8-bit unsigned operands, the output equals their exact unsigned product, 16 bits wide.
- R2: With the output register enabled (the default), the output shows the product of the operands present at the previous rising clock edge. It does not change between edges when the operands change.
- R3: While the active-low reset is low, the output is zero, whether or not a clock edge has occurred.
- R4: When either operand is zero, the product is zero.
- R5: When the second operand is one, the product equals the first operand, zero-extended to 16 bits.
- R6: The largest operands, 255 times 255, give 0xFE01 with no bit lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| a | input | 8 | First unsigned operand |
| b | input | 8 | Second unsigned operand |
| p | output | 16 | Unsigned product |

## Verification
On every clock, the assertions check the following against the operands sampled one edge earlier:
- the registered output equals their arithmetic product;
- a zero operand gives zero;
- a unit second operand passes the first operand through;
- the all-ones case gives 0xFE01.

Only the bench can show three further behaviours. It sweeps all 65,536 operand pairs, which covers every carry path in the adder tree. It shows that the output holds when the operands change between edges. It shows that reset clears the output at once, without a clock.

// File: rtl/vc_mult8.sv
module vc_mult8 #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  a,
  input  logic [7:0]  b,
  output logic [15:0] p
);

  function automatic logic [3:0] cell2(input logic [1:0] x, input logic [1:0] y);
    logic c1;
    logic [3:0] r;
    r[0] = x[0] & y[0];
    r[1] = (x[1] & y[0]) ^ (x[0] & y[1]);
    c1   = (x[1] & y[0]) & (x[0] & y[1]);
    r[2] = (x[1] & y[1]) ^ c1;
    r[3] = (x[1] & y[1]) & c1;
    return r;
  endfunction

  function automatic logic [15:0] rca(input logic [15:0] x, input logic [15:0] y);
    logic cy;
    logic [15:0] s;
    cy = 1'b0;
    for (int i = 0; i < 16; i++) begin
      s[i] = x[i] ^ y[i] ^ cy;
      cy   = (x[i] & y[i]) | (cy & (x[i] ^ y[i]));
    end
    return s;
  endfunction

  function automatic logic [7:0] mul4(input logic [3:0] x, input logic [3:0] y);
    logic [15:0] ll, lh, hl, hh, t0, t1;
    ll = {12'd0, cell2(x[1:0], y[1:0])};
    lh = {10'd0, cell2(x[1:0], y[3:2]), 2'd0};
    hl = {10'd0, cell2(x[3:2], y[1:0]), 2'd0};
    hh = {8'd0,  cell2(x[3:2], y[3:2]), 4'd0};
    t0 = rca(ll, lh);
    t1 = rca(hl, hh);
    return rca(t0, t1)[7:0];
  endfunction

  logic [15:0] q_ll, q_lh, q_hl, q_hh, s_lo, s_hi, prod;

  assign q_ll = {8'd0, mul4(a[3:0], b[3:0])};
  assign q_lh = {4'd0, mul4(a[3:0], b[7:4]), 4'd0};
  assign q_hl = {4'd0, mul4(a[7:4], b[3:0]), 4'd0};
  assign q_hh = {mul4(a[7:4], b[7:4]), 8'd0};
  assign s_lo = rca(q_ll, q_lh);
  assign s_hi = rca(q_hl, q_hh);
  assign prod = rca(s_lo, s_hi);

  generate
    if (REG_OUT) begin : g_reg
      logic [15:0] p_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) p_q <= '0;
        else        p_q <= prod;
      assign p = p_q;

      a_r2_registered_product: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> p == 16'($past(a) * $past(b)));
      a_r4_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(a) == 8'd0 || $past(b) == 8'd0)) |-> p == 16'd0);
      a_r5_unit_operand: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(b) == 8'd1) |-> p == {8'd0, $past(a)});
      a_r6_max_operands: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(a) == 8'hFF && $past(b) == 8'hFF) |-> p == 16'hFE01);
    end else begin : g_comb
      assign p = prod;
    end
  endgenerate

endmodule

// File: tb/sim_vc_mult8.sv
module sim_vc_mult8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic [15:0] p;
  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  vc_mult8 u0 (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .p(p));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R3 reset", p, 16'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        @(negedge clk);
        if (exp_q.size() > 0) check(tag_q.pop_front(), p, exp_q.pop_front());
        a = 8'(i); b = 8'(j);
        exp_q.push_back(16'(i * j));
        if (i == 255 && j == 255)   tag_q.push_back("R6 max");
        else if (i == 0 || j == 0)  tag_q.push_back("R4 zero");
        else if (j == 1)            tag_q.push_back("R5 unit");
        else                        tag_q.push_back("R1 product");
      end
    end
    @(negedge clk);
    check(tag_q.pop_front(), p, exp_q.pop_front());
    // R2: operands change between edges; output must hold until the next edge
    a = 8'd3; b = 8'd5;
    #1;
    check("R2 hold", p, 16'hFE01);
    @(negedge clk);
    check("R2 latency", p, 16'd15);
    // R3: asynchronous clear without a clock edge
    #1 rst_n = 1'b0;
    #1 check("R3 async reset", p, 16'd0);
    finish_run();
  end
endmodule